// File: doc/BRIEF.md
# Banked UART Register Decoder

This block holds the control registers of a 16550-style serial port that has been extended with extra registers. Several of those registers share a single bus offset. The value most recently written to the line control register picks one of three access modes, and the mode decides which physical register an access at a shared offset reaches. The three modes are operational, configuration A and configuration B. The block sits on a simple synchronous bus. A write is captured on the rising clock edge while `wr_en` is high. Read data is a combinational function of the address and the current register state.

The shifter, the baud generator and the FIFOs live elsewhere. This block only exports its stored values to them. An enhanced-enable bit unlocks the upper interrupt-enable bits and the trigger-level submode bit of the modem control register. The divisor latches are guarded: a write to them only takes effect while the UART is disabled and sleep is off. Any refused divisor write sets an error flag that stays set.

Top module: `uart_regbank`

## Requirements
- R1: The line control register is read and written at offset 3 in every mode, and it resets to 0x00.
- R2: Mode selection follows the line control value. A value of exactly 0xBF selects configuration B. Any other value with bit 7 set selects configuration A. A value with bit 7 clear selects operational mode.
- R3: In configuration B, offset 2 reads and writes the enhanced feature register, which resets to 0. Its bit 4 is enhanced enable, and bits 7, 6 and 5 are the CTS, RTS and special-character controls. In the other two modes, offset 2 reads 0 and writes to it are ignored.
- R4: In both configuration modes, offset 0 is the divisor low byte and offset 1 is the divisor high byte. In operational mode, offset 1 is the interrupt enable register and offset 0 reads 0.
- R5: Interrupt enable bits 3:0 are always writable. Bits 7:4 keep their old value on a write unless enhanced enable is 1.
- R6: The modem control register is at offset 4 in operational mode and in configuration A. Its bit 6 (trigger-level submode) keeps its old value on a write unless enhanced enable is 1. Its other bits take the written data. In configuration B, offset 4 reads 0.
- R7: A divisor write takes effect only while the mode field equals 7 and interrupt enable bit 4 is 0. Otherwise the divisor is unchanged and `div_err` goes high. Once high, `div_err` stays high until reset.
- R8: The mode definition register is at offset 8 in every mode. It is a 3-bit field: 0 = 16x, 1 = SIR, 2 = 16x auto-baud, 3 = 13x, 4 = MIR, 5 = FIR, 6 = CIR, 7 = disabled. It resets to 7, and bits 7:3 read as 0.
- R9: The supplementary control register is at offset 0x10 in every mode. It is 8 bits wide and resets to 0. Bit 7 sets RX trigger granularity to 1, bit 6 sets TX trigger granularity to 1, and bit 3 relates to TX empty.
- R10: Reads of any offset not mapped in the current mode return 0.
- R11: `div_latch` outputs {high byte, low byte} of the divisor. The other outputs export their registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| line_ctrl | output | 8 | Line control value |
| int_en | output | 8 | Interrupt enable value |
| modem_ctrl | output | 8 | Modem control value |
| feat_ctrl | output | 8 | Enhanced feature value |
| mode_sel | output | 3 | Mode definition field |
| supp_ctrl | output | 8 | Supplementary control value |
| div_latch | output | 16 | Divisor {high, low} |
| div_err | output | 1 | Sticky refused-divisor-write flag |

## Verification
The same offsets are accessed in each of the three modes, so any mode that is confused with another shows up at once. Offset 2 tells configuration B apart from configuration A. Offsets 0 and 1 tell the configuration modes apart from operational mode. Offset 4 tells configuration B apart from the other two. The gated bits are written as all-ones, first with enhanced enable clear and then with it set, so both the locked and the unlocked paths are visible. Divisor writes are tried under three conditions: the mode is disabled with sleep off, sleep is on, and the mode field is not 7. The first is accepted and the other two are refused, and the error flag is then checked to stay set.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int ADDR_W  = 5,
  parameter int MDR_OFF = 8,
  parameter int SCR_OFF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        line_ctrl,
  output logic [7:0]        int_en,
  output logic [7:0]        modem_ctrl,
  output logic [7:0]        feat_ctrl,
  output logic [2:0]        mode_sel,
  output logic [7:0]        supp_ctrl,
  output logic [15:0]       div_latch,
  output logic              div_err
);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EFR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MDR = ADDR_W'(MDR_OFF);
  localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(SCR_OFF);
  localparam logic [7:0]        CFG_B = 8'hBF;

  logic [7:0] lcr_q, ier_q, mcr_q, efr_q, scr_q, dll_q, dlh_q;
  logic [2:0] mdr_q;
  logic       err_q;

  wire mode_b   = (lcr_q == CFG_B);
  wire cfg_any  = lcr_q[7];
  wire enh      = efr_q[4];
  wire div_ok   = (mdr_q == 3'd7) && !ier_q[4];
  wire div_hit  = wr_en && cfg_any && (addr == A_LO || addr == A_HI);
  wire mcr_vis  = !mode_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q <= 8'h00; ier_q <= 8'h00; mcr_q <= 8'h00; efr_q <= 8'h00;
      scr_q <= 8'h00; dll_q <= 8'h00; dlh_q <= 8'h00; mdr_q <= 3'd7;
      err_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_LCR: lcr_q <= wdata;
        A_MDR: mdr_q <= wdata[2:0];
        A_SCR: scr_q <= wdata;
        A_EFR: if (mode_b) efr_q <= wdata;
        A_MCR: if (mcr_vis) mcr_q <= {wdata[7], enh ? wdata[6] : mcr_q[6], wdata[5:0]};
        A_HI:  if (!cfg_any) ier_q <= {enh ? wdata[7:4] : ier_q[7:4], wdata[3:0]};
        default: ;
      endcase
      if (div_hit) begin
        if (div_ok) begin
          if (addr == A_LO) dll_q <= wdata;
          else              dlh_q <= wdata;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      A_LCR: rdata = lcr_q;
      A_MDR: rdata = {5'b0, mdr_q};
      A_SCR: rdata = scr_q;
      A_EFR: rdata = mode_b ? efr_q : 8'h00;
      A_MCR: rdata = mcr_vis ? mcr_q : 8'h00;
      A_LO:  rdata = cfg_any ? dll_q : 8'h00;
      A_HI:  rdata = cfg_any ? dlh_q : ier_q;
      default: rdata = 8'h00;
    endcase
  end

  assign line_ctrl  = lcr_q;
  assign int_en     = ier_q;
  assign modem_ctrl = mcr_q;
  assign feat_ctrl  = efr_q;
  assign mode_sel   = mdr_q;
  assign supp_ctrl  = scr_q;
  assign div_latch  = {dlh_q, dll_q};
  assign div_err    = err_q;

  a_r7_div_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hit && !div_ok) |=> ($stable(div_latch) && div_err));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

  a_r5_ier_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HI && !lcr_q[7] && !feat_ctrl[4]) |=> (int_en[7:4] == $past(int_en[7:4])));

  a_r3_efr_mode_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EFR && line_ctrl == 8'hBF) |=> (feat_ctrl == $past(wdata)));

  a_r3_efr_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EFR && line_ctrl != 8'hBF) |=> $stable(feat_ctrl));

  a_r1_lcr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LCR) |=> (line_ctrl == $past(wdata)));

  a_r6_mcr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCR && !feat_ctrl[4]) |=> (modem_ctrl[6] == $past(modem_ctrl[6])));
endmodule

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, line_ctrl, int_en, modem_ctrl, feat_ctrl, supp_ctrl;
  logic [2:0] mode_sel;
  logic [15:0] div_latch;
  logic div_err;

  uart_regbank #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .line_ctrl(line_ctrl), .int_en(int_en), .modem_ctrl(modem_ctrl),
    .feat_ctrl(feat_ctrl), .mode_sel(mode_sel), .supp_ctrl(supp_ctrl),
    .div_latch(div_latch), .div_err(div_err));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit pend = 1'b0, done = 1'b0;
  int    sel_q[$];
  int    exp_q[$];
  string tag_q[$];

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = 8'(d); wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // sel: 0 = rdata at address a, 1 = div_err, 2 = div_latch
  task automatic expect_val(input int sel, input int a, input int e, input string tag);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0;
    sel_q.push_back(sel); exp_q.push_back(e); tag_q.push_back(tag);
    pend = 1'b1;
    @(posedge clk);
    #1 pend = 1'b0;
  endtask

  always @(posedge clk) begin
    if (pend && sel_q.size() > 0) begin
      int s, e, act;
      string t;
      s = sel_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      act = (s == 0) ? int'(rdata) : (s == 1) ? int'(div_err) : int'(div_latch);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", t, act, e);
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_val(0, 3, 8'h00, "R1 lcr reset");
    expect_val(0, 8, 8'h07, "R8 mdr reset");
    expect_val(0, 16, 8'h00, "R9 scr reset");
    expect_val(0, 1, 8'h00, "R4 ier reset");
    expect_val(1, 0, 0, "R7 err reset");
    // operational mode, enhanced enable off
    wr(1, 8'hFF);
    expect_val(0, 1, 8'h0F, "R5 ier upper locked");
    wr(4, 8'h53);
    expect_val(0, 4, 8'h13, "R6 mcr bit6 locked");
    wr(2, 8'hFF);
    expect_val(0, 2, 8'h00, "R3 offset2 op reads 0");
    // configuration B
    wr(3, 8'hBF);
    expect_val(0, 2, 8'h00, "R3 efr untouched by op write");
    expect_val(0, 3, 8'hBF, "R1 lcr in mode B");
    wr(2, 8'h10);
    expect_val(0, 2, 8'h10, "R3 efr write");
    expect_val(0, 4, 8'h00, "R6 offset4 unmapped in B");
    wr(0, 8'h1A);
    wr(1, 8'h02);
    expect_val(0, 0, 8'h1A, "R4 dll");
    expect_val(0, 1, 8'h02, "R4 dlh");
    expect_val(2, 0, 16'h021A, "R11 div_latch");
    expect_val(1, 0, 0, "R7 accepted no err");
    // operational, enhanced unlocked
    wr(3, 8'h00);
    wr(1, 8'hF5);
    expect_val(0, 1, 8'hF5, "R5 ier upper unlocked");
    wr(4, 8'h40);
    expect_val(0, 4, 8'h40, "R6 mcr bit6 unlocked");
    expect_val(0, 0, 8'h00, "R4 offset0 op reads 0");
    // configuration A, sleep set
    wr(3, 8'h80);
    expect_val(0, 2, 8'h00, "R2 mode A not B");
    expect_val(0, 4, 8'h40, "R6 mcr in mode A");
    wr(0, 8'h33);
    expect_val(1, 0, 1, "R7 refused on sleep");
    expect_val(0, 0, 8'h1A, "R7 dll kept");
    // mode field not 7
    wr(3, 8'h00);
    wr(1, 8'h00);
    wr(8, 8'hFD);
    expect_val(0, 8, 8'h05, "R8 mdr 3-bit");
    wr(3, 8'h83);
    wr(0, 8'h44);
    expect_val(0, 0, 8'h1A, "R7 refused on mode");
    expect_val(1, 0, 1, "R7 err sticky");
    wr(8, 8'h07);
    wr(0, 8'h44);
    expect_val(0, 0, 8'h44, "R7 accepted when disabled");
    expect_val(1, 0, 1, "R7 err still sticky");
    wr(16, 8'hC8);
    expect_val(0, 16, 8'hC8, "R9 scr write");
    expect_val(0, 5, 8'h00, "R10 unmapped 5");
    expect_val(0, 31, 8'h00, "R10 unmapped 31");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule